// File: doc/BRIEF.md
# Multi-CPU System Interrupt Router

This block gathers 32 level-sensitive hardware interrupt sources and turns them into processor interrupt levels for a group of CPUs. Every source has a fixed processor level. A source that is pending and not disabled raises its level on one CPU, the target, which software selects. Sources whose level is 15 are the exception: they raise level 15 on every CPU. Each CPU also has a private timer request, which shows up as level 14 on that CPU alone.

Software uses a small register window of 32-bit words. One register reads back the pending sources. One reads back the disable vector. Two write-only registers set and clear disable bits with write-one semantics. One register selects the target CPU. Bit 31 of the disable vector is a global kill. While it is set, nothing reaches any CPU.

Each CPU's output is a registered 15-bit vector of pending levels. It follows the sources, the timer inputs and the register writes, and updates on the same clock edge that captures them.

Top module: `irq_router`

## Requirements
- R1: After reset the pending vector is 0, the disable vector is 0x0FA2007F, the target is CPU 0, and every output level bit is 0.
- R2: A write to word offset 2 clears each disable bit whose data bit is 1 and that lies in the writable mask (the complement of 0x0FA2007F). The pending vector is left unchanged.
- R3: A write to word offset 3 sets each disable bit whose data bit is 1 and that lies in the writable mask. The pending vector is left unchanged.
- R4: Disable bits that are 1 in 0x0FA2007F stay 1 whatever is written to offsets 2 and 3.
- R5: The pending vector copies the 32 source inputs on every clock edge. Reading offset 0 returns it ANDed with the writable mask.
- R6: Source j maps to a level by this table, j = 0..31 in order: 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. A source that maps to level 0 has no effect on any output. Level L of CPU c appears at output bit c*15 + L - 1.
- R7: A write to offset 4 sets the target to the written value ANDed with (NCPU - 1), and reading offset 4 returns it. Levels 1 to 13 appear only on the target CPU, and only from sources that are pending and not disabled.
- R8: When any source of level 15 is pending and the kill bit is clear, level 15 is raised on every CPU, whatever that source's own disable bit holds.
- R9: While disable bit 31 is 1, every output bit of every CPU is 0, including levels 14 and 15.
- R10: Timer input c raises level 14 on CPU c only. It does not depend on the target or on any source disable bit.
- R11: The outputs are registered. They reflect the inputs and register writes captured at the same clock edge that updates the state.
- R12: Reading offset 1 returns the disable vector. Reads of offsets 2, 3, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Hardware interrupt source levels, active high |
| timer_i | input | NCPU | Per-CPU timer requests, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cpu_lvl_o | output | NCPU*15 | Pending levels 1 to 15 for each CPU, registered |

## Verification
The bench sweeps one source at a time through all 32 positions. A wrong entry in the level table shows up as a level on the wrong output bit, or as a reserved source that raises a level. It writes all ones to the enable and disable registers. A design that does not mask the reserved bits would change them, or would set the kill bit by accident. It then disables every source while a level-15 source is active. A design that wrongly gates the broadcast with the source's disable bit would drop level 15 on all CPUs. A design that also cleared pending on disable would be caught by the pending read-back. Target writes with high bits set, timer requests on non-target CPUs, and the kill bit with timers active each separate a correct design from one that truncates badly, routes timers by target, or lets level 14 or 15 pass the kill.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    localparam int NSRC      = 32;
    localparam int NLVL      = 15;
    localparam int KILL_BIT  = 31;
    localparam int TIMER_LVL = 14;
    localparam int BCAST_LVL = 15;

    localparam logic [NSRC-1:0] FIXED_DIS = 32'h0FA2_007F;
    localparam logic [NSRC-1:0] WR_MASK   = ~FIXED_DIS;

    localparam logic [2:0] OFS_PEND = 3'd0;
    localparam logic [2:0] OFS_DIS  = 3'd1;
    localparam logic [2:0] OFS_ENA  = 3'd2;
    localparam logic [2:0] OFS_MASK = 3'd3;
    localparam logic [2:0] OFS_TGT  = 3'd4;

    // Processor level for each source; 0 means the source is unused.
    function automatic logic [3:0] src_level(input int unsigned j);
        case (j)
            0, 7:                 src_level = 4'd2;
            1, 8:                 src_level = 4'd3;
            2, 9:                 src_level = 4'd5;
            3, 10:                src_level = 4'd7;
            4, 11, 21:            src_level = 4'd9;
            5, 12, 22:            src_level = 4'd11;
            6, 13, 17:            src_level = 4'd13;
            14, 15:               src_level = 4'd12;
            16:                   src_level = 4'd6;
            18:                   src_level = 4'd4;
            19:                   src_level = 4'd10;
            20:                   src_level = 4'd8;
            27, 28, 29, 30:       src_level = 4'd15;
            default:              src_level = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/irqr_regs.sv
module irqr_regs
    import irqr_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [NSRC-1:0]   wr_data,
    output logic [NSRC-1:0]   pend_d,
    output logic [NSRC-1:0]   dis_d,
    output logic [TGT_W-1:0]  tgt_d,
    output logic [NSRC-1:0]   pend_q,
    output logic [NSRC-1:0]   dis_q,
    output logic [TGT_W-1:0]  tgt_q
);

    typedef struct packed {
        logic [NSRC-1:0]  pend;
        logic [NSRC-1:0]  dis;
        logic [TGT_W-1:0] tgt;
    } state_t;

    state_t          st_d, st_q;
    logic [NSRC-1:0] wbits;

    always_comb begin
        st_d      = st_q;
        wbits     = wr_data & WR_MASK;
        st_d.pend = src_i;
        if (wr_en) begin
            case (wr_addr)
                OFS_ENA:  st_d.dis = st_q.dis & ~wbits;
                OFS_MASK: st_d.dis = st_q.dis | wbits;
                OFS_TGT:  st_d.tgt = wr_data[TGT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.dis  <= FIXED_DIS;
            st_q.tgt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d = st_d.pend;
    assign dis_d  = st_d.dis;
    assign tgt_d  = st_d.tgt;
    assign pend_q = st_q.pend;
    assign dis_q  = st_q.dis;
    assign tgt_q  = st_q.tgt;

endmodule

// File: rtl/irqr_map.sv
module irqr_map
    import irqr_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] dis,
    output logic [NLVL:1]   lvl_vec,
    output logic            bcast
);

    always_comb begin
        lvl_vec = '0;
        bcast   = 1'b0;
        for (int j = 0; j < NSRC; j++) begin
            if (pend[j]) begin
                if (src_level(j) == 4'(BCAST_LVL)) begin
                    bcast = 1'b1;
                end else if (src_level(j) != 4'd0 && !dis[j]) begin
                    lvl_vec[src_level(j)] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irqr_fanout.sv
module irqr_fanout
    import irqr_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int TGT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLVL:1]        lvl_vec,
    input  logic                 bcast,
    input  logic                 kill,
    input  logic [TGT_W-1:0]     tgt,
    input  logic [NCPU-1:0]      timer,
    output logic [NCPU*NLVL-1:0] lvl_o
);

    logic [NCPU*NLVL-1:0] lvl_d, lvl_q;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NLVL:1] v;
        always_comb begin
            v = '0;
            if (!kill) begin
                if (tgt == TGT_W'(c)) begin
                    v = lvl_vec;
                end
                v[TIMER_LVL] = v[TIMER_LVL] | timer[c];
                v[BCAST_LVL] = v[BCAST_LVL] | bcast;
            end
        end
        assign lvl_d[c*NLVL +: NLVL] = v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irqr_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          src_i,
    input  logic [NCPU-1:0]      timer_i,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NCPU*15-1:0]   cpu_lvl_o
);

    localparam int TGT_W = $clog2(NCPU);

    logic [NSRC-1:0]  pend_d, dis_d, pend_q, dis_q;
    logic [TGT_W-1:0] tgt_d, tgt_q;
    logic [NLVL:1]    lvl_vec;
    logic             bcast;

    irqr_regs #(.TGT_W(TGT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .pend_d  (pend_d),
        .dis_d   (dis_d),
        .tgt_d   (tgt_d),
        .pend_q  (pend_q),
        .dis_q   (dis_q),
        .tgt_q   (tgt_q)
    );

    irqr_map u_map (
        .pend    (pend_d),
        .dis     (dis_d),
        .lvl_vec (lvl_vec),
        .bcast   (bcast)
    );

    irqr_fanout #(.NCPU(NCPU), .TGT_W(TGT_W)) u_fan (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_vec (lvl_vec),
        .bcast   (bcast),
        .kill    (dis_d[KILL_BIT]),
        .tgt     (tgt_d),
        .timer   (timer_i),
        .lvl_o   (cpu_lvl_o)
    );

    always_comb begin
        case (reg_addr)
            OFS_PEND: reg_rdata = pend_q & WR_MASK;
            OFS_DIS:  reg_rdata = dis_q;
            OFS_TGT:  reg_rdata = 32'(tgt_q);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqr_chk.sv
module irqr_chk
    import irqr_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int TGT_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [31:0]          src_i,
    input logic                 reg_wr,
    input logic [2:0]           reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          pend_q,
    input logic [31:0]          dis_q,
    input logic [TGT_W-1:0]     tgt_q,
    input logic [NCPU*15-1:0]   cpu_lvl_o
);

    assert_ena_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ENA) |=>
        ((dis_q & $past(reg_wdata) & WR_MASK) == '0));

    assert_dis_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MASK) |=>
        ((dis_q & $past(reg_wdata) & WR_MASK) == ($past(reg_wdata) & WR_MASK)));

    assert_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dis_q & FIXED_DIS) == FIXED_DIS));

    assert_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q == $past(src_i)));

    assert_tgt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_TGT) |=> (tgt_q == $past(reg_wdata[TGT_W-1:0])));

    assert_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q[KILL_BIT] |-> (cpu_lvl_o == '0));

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assert_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_lvl_o[c*NLVL + BCAST_LVL - 1] == cpu_lvl_o[BCAST_LVL - 1]));

        assert_nontgt_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_q != TGT_W'(c)) |-> (cpu_lvl_o[c*NLVL +: 13] == '0));
    end

endmodule

bind irq_router irqr_chk #(.NCPU(NCPU), .TGT_W(TGT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend_q    (pend_q),
    .dis_q     (dis_q),
    .tgt_q     (tgt_q),
    .cpu_lvl_o (cpu_lvl_o)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;

    localparam int NCPU = 4;
    localparam int OW   = NCPU * 15;
    localparam logic [31:0] FIX = 32'h0FA2_007F;
    localparam logic [31:0] WM  = ~FIX;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     src = '0;
    logic [NCPU-1:0] tmr = '0;
    logic            wr = 1'b0;
    logic [2:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [OW-1:0]   lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // level table for sources 0..31
    int lvl_tab[32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                        6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

    // reference state
    logic [31:0] m_pend = '0;
    logic [31:0] m_dis  = FIX;
    int          m_tgt  = 0;
    logic [NCPU-1:0] m_tmr = '0;

    always #4 clk = ~clk;

    irq_router #(.NCPU(NCPU)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .timer_i   (tmr),
        .reg_wr    (wr),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .cpu_lvl_o (lvl)
    );

    function automatic logic [OW-1:0] exp_out();
        logic [OW-1:0] e = '0;
        if (!m_dis[31]) begin
            for (int c = 0; c < NCPU; c++) begin
                for (int j = 0; j < 32; j++) begin
                    if (m_pend[j] && lvl_tab[j] != 0) begin
                        if (lvl_tab[j] == 15) e[c*15 + 14] = 1'b1;
                        else if (!m_dis[j] && c == m_tgt) e[c*15 + lvl_tab[j] - 1] = 1'b1;
                    end
                end
                if (m_tmr[c]) e[c*15 + 13] = 1'b1;
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0:    return m_pend & WM;
            3'd1:    return m_dis;
            3'd4:    return 32'(m_tgt);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [31:0] s, input logic [NCPU-1:0] t,
                       input logic w, input logic [2:0] a, input logic [31:0] d,
                       input string req);
        @(negedge clk);
        src = s; tmr = t; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        m_pend = s;
        m_tmr  = t;
        if (w) begin
            case (a)
                3'd2: m_dis = m_dis & ~(d & WM);
                3'd3: m_dis = m_dis | (d & WM);
                3'd4: m_tgt = int'(d) & (NCPU - 1);
                default: ;
            endcase
        end
        check(req, "levels", 64'(lvl), 64'(exp_out()));
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        @(negedge clk);
        wr = 1'b0; addr = a;
        #1;
        check(req, "read", 64'(rdata), 64'(exp_rd(a)));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "levels in reset", 64'(lvl), 64'h0);
        addr = 3'd0; #1; check("R1", "pending", 64'(rdata), 64'h0);
        addr = 3'd1; #1; check("R1", "disable", 64'(rdata), 64'(FIX));
        addr = 3'd4; #1; check("R1", "target", 64'(rdata), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 sweep one source at a time
        for (int j = 0; j < 32; j++) cyc(32'(1) << j, '0, 1'b0, 3'd0, 32'h0, "R6");

        // R5 pending read-back and R12 read map
        cyc(32'hFFFF_FFFF, '0, 1'b0, 3'd0, 32'h0, "R5");
        rd(3'd0, "R5");
        rd(3'd1, "R12");
        rd(3'd2, "R12");
        rd(3'd5, "R12");
        rd(3'd7, "R12");

        // R3 disable set, pending untouched
        cyc(32'hFFFF_FFFF, '0, 1'b1, 3'd3, 32'h0000_FF80, "R3");
        rd(3'd1, "R3");
        rd(3'd0, "R3");

        // R2 enable clear, pending untouched
        cyc(32'hFFFF_FFFF, '0, 1'b1, 3'd2, 32'h0000_0F00, "R2");
        rd(3'd1, "R2");
        rd(3'd0, "R2");

        // R4 reserved bits stay set
        cyc(32'hFFFF_FFFF, '0, 1'b1, 3'd2, 32'hFFFF_FFFF, "R4");
        rd(3'd1, "R4");
        cyc(32'hFFFF_FFFF, '0, 1'b1, 3'd3, 32'h7FFF_FFFF, "R4");
        rd(3'd1, "R4");
        cyc(32'hFFFF_FFFF, '0, 1'b1, 3'd2, 32'h7FFF_FFFF, "R4");
        rd(3'd1, "R4");

        // R7 target selection with truncation
        cyc(32'h0000_FF80, '0, 1'b1, 3'd4, 32'h0000_0006, "R7");
        rd(3'd4, "R7");
        cyc(32'h0040_0100, '0, 1'b1, 3'd4, 32'hFFFF_FFFD, "R7");
        rd(3'd4, "R7");

        // R8 broadcast of level 15 ignores per-source disable
        cyc(32'h1000_0000, '0, 1'b1, 3'd3, 32'h7FFF_FFFF, "R8");
        cyc(32'h0800_0000, '0, 1'b0, 3'd0, 32'h0, "R8");
        cyc(32'h1000_0000, '0, 1'b1, 3'd2, 32'h7FFF_FFFF, "R8");

        // R10 timers go to their own CPU only
        cyc(32'h0, 4'b0101, 1'b0, 3'd0, 32'h0, "R10");
        cyc(32'h0000_0080, 4'b1010, 1'b0, 3'd0, 32'h0, "R10");

        // R9 global kill blocks everything
        cyc(32'hFFFF_FFFF, 4'b1111, 1'b1, 3'd3, 32'h8000_0000, "R9");
        cyc(32'hFFFF_FFFF, 4'b1111, 1'b0, 3'd0, 32'h0, "R9");
        rd(3'd1, "R9");
        cyc(32'hFFFF_FFFF, 4'b1111, 1'b1, 3'd2, 32'h8000_0000, "R9");

        // R11 output follows the edge that captures the input
        cyc(32'h0, '0, 1'b0, 3'd0, 32'h0, "R11");
        cyc(32'h0000_0080, '0, 1'b0, 3'd0, 32'h0, "R11");
        cyc(32'h0, 4'b0001, 1'b1, 3'd4, 32'h0, "R11");

        // mixed traffic against the model
        lf = 32'hACE1_1234;
        for (int k = 0; k < 400; k++) begin
            logic [2:0] a;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a = 3'(2 + (int'(lf[9:8]) % 3));
            cyc(lf, NCPU'(lf[17:14]), lf[12] & lf[13], a,
                {lf[3] & lf[4] & lf[5], lf[30:0]}, "R6");
            if (k % 16 == 0) rd(3'(int'(lf[22:20])), "R12");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule